// File: doc/BRIEF.md
# LED Blink Pattern Sequencer

This block drives a bank of active-low indicator LEDs, three by default. Each LED has its own mode: dark, steadily lit, or blinking. A blinking LED stays lit for a programmed number of time units and then goes dark for a separately programmed number of units. It can also be set to stretch the dark gap to a third, longer length after every N lit periods, and then begin counting a new group. A time unit is a sixteenth of a second, given as `UNIT_CYCLES` clocks of the block clock.

Settings arrive through a single-cycle write strobe. Each write carries the LED index, the mode and four bytes: lit length, gap length, group size and long-gap length. A combinational read port returns the 2-bit mode code of any LED. A power-good input blanks every LED at once while keeping its settings, and brings them back when power returns. The `led_active` output tells the power controller that at least one LED needs the clock running. The power controller uses it to hold off low-power entry.

Top module: `led_blink_seq`

## Requirements
- R1: After reset every `led_n` bit is 1, `led_active` is 0 and every LED reports mode code 0.
- R2: A write (`wr_en`=1, `wr_led` below the LED count, `wr_mode` 0, 1 or 2) takes effect at the next rising clock edge. A write whose `wr_led` is 3 or whose `wr_mode` is 3 changes nothing.
- R3: `rd_status` returns the mode of LED `rd_sel` as a code: 0 = dark, 1 = lit, 2 = blinking. When `rd_sel` is not a valid LED index (3), it returns 3.
- R4: In mode 0 the LED's `led_n` bit is 1. In mode 1 it is 0 for as long as power is good.
- R5: In mode 2 the LED is lit for `wr_on` units and then dark for `wr_off` units, repeating. One unit is `UNIT_CYCLES` clocks. The first lit cycle is the one right after the write edge.
- R6: With group size M > 0, the dark gap after every M-th lit period lasts `wr_long` units in place of `wr_off`, and the count of lit periods then starts over. M = 0 disables the long gap.
- R7: A length field of 0 (lit, gap or long gap) is timed as one unit.
- R8: Any accepted write to an LED restarts its pattern at the first cycle of the lit period, wherever it was before.
- R9: While `pwr_good` is 0, all `led_n` bits are 1 and `led_active` is 0. The stored modes are still reported, and writes are still stored.
- R10: When `pwr_good` returns to 1, each LED resumes its stored mode. A blinking LED starts again at the beginning of its lit period.
- R11: `led_active` is 1 exactly when `pwr_good` is 1 and at least one LED is in mode 1 or 2. This includes a blinking LED that is in a dark phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_led | input | 2 | Index of the LED to configure |
| wr_mode | input | 2 | Mode code: 0 dark, 1 lit, 2 blink |
| wr_on | input | 8 | Lit length in units |
| wr_off | input | 8 | Normal gap length in units |
| wr_grp | input | 8 | Lit periods per group, 0 = no long gap |
| wr_long | input | 8 | Long-gap length in units |
| rd_sel | input | 2 | LED index for the status read |
| rd_status | output | 2 | Mode code of the selected LED, 3 if the index is invalid |
| pwr_good | input | 1 | High while supply is healthy |
| led_n | output | 3 | LED drives, active low |
| led_active | output | 1 | Some LED needs the clock running |

## Verification
The bench compares each blinking LED, cycle by cycle, against a closed-form position in the group period. It uses several lit, gap and group settings, including a group size of 1 and lengths of 0. A design that counts one unit too many or too few, inserts the long gap after the wrong lit period, or does not restart the group count would drift from that model within a few periods.

Directed tests cover the following cases:
- A rewrite made in the middle of a dark gap. A design that does not restart the phase would stay dark.
- Writes to the invalid index and writes with mode 3. A design that does not ignore them would corrupt the stored modes.
- A power-fail window during which a write is also made. This catches a design that forgets its settings or lights an LED while blanked.
- The restart after power returns. This catches a design that resumes mid-pattern.
- `led_active` sampled during a dark blink phase. A design that derives the flag from the pins would drop it there.

// File: rtl/led_seq_pkg.sv
`timescale 1ns/1ps
package led_seq_pkg;

  typedef enum logic [1:0] {
    LM_OFF   = 2'd0,
    LM_ON    = 2'd1,
    LM_BLINK = 2'd2,
    LM_NONE  = 2'd3
  } led_mode_e;

  typedef enum logic [1:0] {
    PH_LIT  = 2'd0,
    PH_GAP  = 2'd1,
    PH_LONG = 2'd2
  } blink_phase_e;

  typedef struct packed {
    led_mode_e  mode;
    logic [7:0] on_u;
    logic [7:0] off_u;
    logic [7:0] grp_cnt;
    logic [7:0] long_u;
  } led_cfg_t;

  // A programmed length of zero still lasts one unit.
  function automatic logic [7:0] eff_units(input logic [7:0] v);
    return (v == 8'd0) ? 8'd1 : v;
  endfunction

  // Length of the phase currently being timed.
  function automatic logic [7:0] phase_len(input blink_phase_e ph, input led_cfg_t cfg);
    case (ph)
      PH_LIT:  return eff_units(cfg.on_u);
      PH_GAP:  return eff_units(cfg.off_u);
      default: return eff_units(cfg.long_u);
    endcase
  endfunction

  // True when the lit period now ending closes a group.
  function automatic logic group_closes(input logic [7:0] grp_cnt, input logic [7:0] done);
    return (grp_cnt != 8'd0) && ((done + 8'd1) == grp_cnt);
  endfunction

endpackage

// File: rtl/led_unit_timer.sv
`timescale 1ns/1ps
module led_unit_timer #(
  parameter int UNIT_CYCLES = 3125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic unit_done
);
  localparam int CW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(UNIT_CYCLES - 1);

  logic [CW-1:0] pre_q;

  assign unit_done = (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart || unit_done) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/led_chan.sv
`timescale 1ns/1ps
module led_chan
  import led_seq_pkg::*;
#(
  parameter int UNIT_CYCLES = 3125000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pwr_good,
  input  logic     load,
  input  led_cfg_t load_cfg,
  output logic [1:0] mode_o,
  output logic     lit_o,
  output logic     unit_o
);
  led_cfg_t     cfg_q;
  blink_phase_e ph_q;
  logic [7:0]   ivl_q;
  logic [7:0]   done_q;
  logic [7:0]   cur_len;
  logic         ivl_last;
  logic         unit_done;

  led_unit_timer #(.UNIT_CYCLES(UNIT_CYCLES)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (load || !pwr_good),
    .unit_done(unit_done)
  );

  assign cur_len  = phase_len(ph_q, cfg_q);
  assign ivl_last = (ivl_q == (cur_len - 8'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{mode: LM_OFF, default: '0};
      ph_q   <= PH_LIT;
      ivl_q  <= '0;
      done_q <= '0;
    end else if (load) begin
      cfg_q  <= load_cfg;
      ph_q   <= PH_LIT;
      ivl_q  <= '0;
      done_q <= '0;
    end else if (!pwr_good) begin
      ph_q   <= PH_LIT;
      ivl_q  <= '0;
      done_q <= '0;
    end else if (unit_done && cfg_q.mode == LM_BLINK) begin
      if (ivl_last) begin
        ivl_q <= '0;
        case (ph_q)
          PH_LIT: begin
            if (group_closes(cfg_q.grp_cnt, done_q)) begin
              ph_q   <= PH_LONG;
              done_q <= '0;
            end else begin
              ph_q   <= PH_GAP;
              done_q <= done_q + 8'd1;
            end
          end
          default: ph_q <= PH_LIT;
        endcase
      end else begin
        ivl_q <= ivl_q + 8'd1;
      end
    end
  end

  assign mode_o = cfg_q.mode;
  assign lit_o  = (cfg_q.mode == LM_ON) || (cfg_q.mode == LM_BLINK && ph_q == PH_LIT);
  assign unit_o = unit_done;
endmodule

// File: rtl/led_status_mux.sv
`timescale 1ns/1ps
module led_status_mux #(
  parameter int NUM_LEDS = 3,
  parameter int SEL_W    = 2
) (
  input  logic [NUM_LEDS-1:0][1:0] modes,
  input  logic [SEL_W-1:0]         sel,
  output logic [1:0]               status
);
  always_comb begin
    status = 2'd3;
    for (int i = 0; i < NUM_LEDS; i++) begin
      if (sel == SEL_W'(i)) status = modes[i];
    end
  end
endmodule

// File: rtl/led_blink_seq.sv
`timescale 1ns/1ps
module led_blink_seq
  import led_seq_pkg::*;
#(
  parameter int NUM_LEDS    = 3,
  parameter int UNIT_CYCLES = 3125000,
  parameter int SEL_W       = $clog2(NUM_LEDS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_led,
  input  logic [1:0]          wr_mode,
  input  logic [7:0]          wr_on,
  input  logic [7:0]          wr_off,
  input  logic [7:0]          wr_grp,
  input  logic [7:0]          wr_long,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic [1:0]          rd_status,
  input  logic                pwr_good,
  output logic [NUM_LEDS-1:0] led_n,
  output logic                led_active
);
  led_cfg_t                  new_cfg;
  logic [NUM_LEDS-1:0]       wr_hit;
  logic [NUM_LEDS-1:0][1:0]  mode_w;
  logic [NUM_LEDS-1:0]       lit_w;
  logic [NUM_LEDS-1:0]       unit_w;
  logic [NUM_LEDS-1:0]       busy_w;

  assign new_cfg = '{mode: led_mode_e'(wr_mode), on_u: wr_on, off_u: wr_off,
                     grp_cnt: wr_grp, long_u: wr_long};

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_chan
    assign wr_hit[i] = wr_en && (wr_led == SEL_W'(i)) && (wr_mode != LM_NONE);

    led_chan #(.UNIT_CYCLES(UNIT_CYCLES)) chan_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwr_good(pwr_good),
      .load    (wr_hit[i]),
      .load_cfg(new_cfg),
      .mode_o  (mode_w[i]),
      .lit_o   (lit_w[i]),
      .unit_o  (unit_w[i])
    );

    assign busy_w[i] = (mode_w[i] != LM_OFF);
  end

  led_status_mux #(.NUM_LEDS(NUM_LEDS), .SEL_W(SEL_W)) mux_i (
    .modes (mode_w),
    .sel   (rd_sel),
    .status(rd_status)
  );

  assign led_n      = ~(lit_w & {NUM_LEDS{pwr_good}});
  assign led_active = pwr_good && (|busy_w);
endmodule

// File: rtl/led_blink_seq_chk.sv
`timescale 1ns/1ps
module led_blink_seq_chk #(
  parameter int NUM_LEDS = 3,
  parameter int SEL_W    = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      pwr_good,
  input logic                      wr_en,
  input logic [SEL_W-1:0]          wr_led,
  input logic [1:0]                wr_mode,
  input logic [SEL_W-1:0]          rd_sel,
  input logic [1:0]                rd_status,
  input logic [NUM_LEDS-1:0]       led_n,
  input logic                      led_active,
  input logic [NUM_LEDS-1:0][1:0]  mode_w
);
  p_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |-> (led_n == {NUM_LEDS{1'b1}} && !led_active));

  p_lit_needs_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (led_n != {NUM_LEDS{1'b1}}) |-> led_active);

  p_valid_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel < SEL_W'(NUM_LEDS)) |-> (rd_status != 2'd3));

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    p_off_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w[i] == 2'd0) |-> led_n[i]);

    p_on_lit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_w[i] == 2'd1 && pwr_good) |-> !led_n[i]);

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_led == SEL_W'(i) && wr_mode == 2'd2) |=> (!led_n[i] || !pwr_good));

    p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_led == SEL_W'(i) && wr_mode == 2'd3) |=> $stable(mode_w[i]));
  end
endmodule

bind led_blink_seq led_blink_seq_chk #(.NUM_LEDS(NUM_LEDS), .SEL_W(SEL_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_good  (pwr_good),
  .wr_en     (wr_en),
  .wr_led    (wr_led),
  .wr_mode   (wr_mode),
  .rd_sel    (rd_sel),
  .rd_status (rd_status),
  .led_n     (led_n),
  .led_active(led_active),
  .mode_w    (mode_w)
);

// File: tb/led_blink_seq_tb_top.sv
`timescale 1ns/1ps
module led_blink_seq_tb_top;
  localparam int U = 2;
  localparam int N = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_led = '0, wr_mode = '0, rd_sel = '0;
  logic [7:0] wr_on = '0, wr_off = '0, wr_grp = '0, wr_long = '0;
  logic [1:0] rd_status;
  logic       pwr_good = 1'b1;
  logic [N-1:0] led_n;
  logic       led_active;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  led_blink_seq #(.NUM_LEDS(N), .UNIT_CYCLES(U)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_led(wr_led), .wr_mode(wr_mode),
    .wr_on(wr_on), .wr_off(wr_off), .wr_grp(wr_grp), .wr_long(wr_long),
    .rd_sel(rd_sel), .rd_status(rd_status), .pwr_good(pwr_good),
    .led_n(led_n), .led_active(led_active)
  );

  // led, mode, on, off, group, long
  localparam logic [35:0] VEC [0:6] = '{
    {2'd0, 2'd2, 8'd2, 8'd3, 8'd0, 8'd0},
    {2'd1, 2'd2, 8'd1, 8'd1, 8'd2, 8'd4},
    {2'd2, 2'd2, 8'd3, 8'd1, 8'd1, 8'd2},
    {2'd0, 2'd2, 8'd0, 8'd0, 8'd0, 8'd0},
    {2'd1, 2'd1, 8'd5, 8'd5, 8'd0, 8'd0},
    {2'd2, 2'd2, 8'd0, 8'd2, 8'd3, 8'd0},
    {2'd0, 2'd0, 8'd1, 8'd1, 8'd0, 8'd0}
  };

  function automatic bit ref_lit(input int mode, input int on, input int off,
                                 input int grp, input int lng, input int t);
    int a, b, m, u, sup, p;
    if (mode == 0) return 1'b0;
    if (mode == 1) return 1'b1;
    a = (on == 0) ? 1 : on;
    b = (off == 0) ? 1 : off;
    m = (lng == 0) ? 1 : lng;
    u = t / U;
    if (grp == 0) return (u % (a + b)) < a;
    sup = grp * a + (grp - 1) * b + m;
    p = u % sup;
    if (p >= grp * a + (grp - 1) * b) return 1'b0;
    return (p % (a + b)) < a;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_write(input int led, input int mode, input int on, input int off,
                          input int grp, input int lng);
    @(negedge clk);
    wr_led = 2'(led); wr_mode = 2'(mode);
    wr_on = 8'(on); wr_off = 8'(off); wr_grp = 8'(grp); wr_long = 8'(lng);
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Compares one LED against the model from pattern cycle t0 on; one check per call.
  task automatic check_pattern(input int led, input int mode, input int on, input int off,
                               input int grp, input int lng, input int t0, input int ncyc,
                               input string tag);
    bit ok = 1'b1;
    int bad_t = 0;
    int act = 0;
    int exp = 0;
    for (int t = t0; t < t0 + ncyc; t++) begin
      if (ok && (led_n[led] != !ref_lit(mode, on, off, grp, lng, t))) begin
        ok = 1'b0; bad_t = t; act = led_n[led];
        exp = !ref_lit(mode, on, off, grp, lng, t);
      end
      @(negedge clk);
    end
    check(ok, $sformatf("%s led%0d t=%0d led_n", tag, led, bad_t), act, exp);
  endtask

  task automatic check_status(input int led, input int exp, input string tag);
    rd_sel = 2'(led);
    #1;
    check(rd_status == 2'(exp), $sformatf("%s status led%0d", tag, led), rd_status, exp);
  endtask

  initial begin
    #4000000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R3 invalid index
    check(led_n == 3'b111, "R1 led_n", led_n, 7);
    check(led_active == 1'b0, "R1 led_active", led_active, 0);
    for (int i = 0; i < N; i++) check_status(i, 0, "R1");
    check_status(3, 3, "R3 invalid index");

    // Table of vectors: R5 R6 R7 R4 and R3 readback
    for (int v = 0; v < 7; v++) begin
      int l, md, on, off, gr, lg;
      {l, md, on, off, gr, lg} = {30'd0, VEC[v][35:34], 30'd0, VEC[v][33:32],
                                  24'd0, VEC[v][31:24], 24'd0, VEC[v][23:16],
                                  24'd0, VEC[v][15:8], 24'd0, VEC[v][7:0]};
      do_write(l, md, on, off, gr, lg);
      check_pattern(l, md, on, off, gr, lg, 0, 60, $sformatf("R5/R6/R7 vec%0d", v));
      check_status(l, md, "R3");
    end

    // R2: ignored writes (index 3, mode 3)
    do_write(0, 1, 0, 0, 0, 0);
    do_write(3, 2, 1, 1, 0, 0);
    check_status(0, 1, "R2 idx3");
    check_status(1, 1, "R2 idx3");
    check_status(2, 2, "R2 idx3");
    do_write(1, 3, 1, 1, 0, 0);
    check_status(1, 1, "R2 mode3");
    check(led_n[1] == 1'b0, "R2 mode3 led1 still lit", led_n[1], 0);

    // R8: rewrite mid-gap restarts at the lit period
    do_write(2, 0, 0, 0, 0, 0);
    do_write(0, 2, 2, 4, 0, 0);
    repeat (6) @(negedge clk);
    check(led_n[0] == 1'b1, "R8 in gap before rewrite", led_n[0], 1);
    do_write(0, 2, 2, 4, 0, 0);
    check_pattern(0, 2, 2, 4, 0, 0, 0, 30, "R8 restart");

    // R11: blinking LED in gap keeps led_active high
    do_write(1, 0, 0, 0, 0, 0);
    do_write(0, 2, 1, 5, 0, 0);
    repeat (3) @(negedge clk);
    check(led_n == 3'b111, "R11 all dark in gap", led_n, 7);
    check(led_active == 1'b1, "R11 active in gap", led_active, 1);
    do_write(0, 0, 0, 0, 0, 0);
    check(led_active == 1'b0, "R11 inactive all off", led_active, 0);

    // R9: power fail blanks, keeps and accepts settings
    do_write(0, 2, 3, 2, 2, 5);
    do_write(1, 1, 0, 0, 0, 0);
    @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    check(led_n == 3'b111, "R9 blanked", led_n, 7);
    check(led_active == 1'b0, "R9 active low", led_active, 0);
    check_status(0, 2, "R9 retained");
    check_status(1, 1, "R9 retained");
    do_write(2, 1, 0, 0, 0, 0);
    check_status(2, 1, "R9 write stored");
    check(led_n[2] == 1'b1, "R9 new write stays dark", led_n[2], 1);
    repeat (4) @(negedge clk);

    // R10: restore, blinking LED restarts at its lit period
    pwr_good = 1'b1;
    @(negedge clk);
    check(led_n[1] == 1'b0 && led_n[2] == 1'b0, "R10 steady LEDs back", led_n, 1);
    check(led_active == 1'b1, "R10 active again", led_active, 1);
    check_pattern(0, 2, 3, 2, 2, 5, 1, 50, "R10 restore");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule